// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line that idles high. A strobe that fires sixteen times per bit period paces it. On every strobe it takes one sample of the synchronised line. A falling edge is accepted as a start bit only when the three samples before it were high. Three further looks inside the start bit then either confirm the start or throw it away as noise. Data bits and the stop bit are each decided by a two-out-of-three vote in the middle of the bit. The block accepts characters of eight or nine data bits, with the least significant bit first.

A finished character is placed in a holding register. Status flags then report data ready, overrun, noise, a bad stop bit and an idle line. Software empties the holding register by reading status and then reading data. That same pair of reads clears all the flags. One interrupt request line merges the data-ready and overrun events with the idle event, and each side has its own enable.

Top module: `uart_os_rx`

## Requirements
- R1: A low sample opens a character only if the three samples just before it were all high. After a long low stretch, two high samples followed by a low frame of all-zero data produce no character. Three high samples followed by the same frame produce data 0x00.
- R2: Within the start bit, samples 3, 5 and 7 (counting the opening low sample as 1) are voted. If the vote is high, reception is abandoned and no flag changes. If the vote is low but the three samples disagree, the character completes with the noise flag set.
- R3: With `len9` low, a frame is one low start bit, eight data bits with bit 0 first, and one high stop bit. The data bits appear on `data_out`, and `bit8_out` is 0.
- R4: With `len9` high, a frame carries nine data bits. The ninth bit received appears on `bit8_out`, and the first eight appear on `data_out`.
- R5: Each data bit and the stop bit is the majority of samples 8, 9 and 10 of that bit. A single inverted sample leaves the data correct but sets `flag_noise`.
- R6: A stop bit whose vote is low sets `flag_frame`. The character is still loaded and `flag_full` is set.
- R7: If a character completes while `flag_full` is set, `flag_ovr` is set, `data_out` keeps the earlier byte, and the new character is lost.
- R8: Once at least one character has been received, `flag_idle` is set after 16 × (frame bits) consecutive high samples: 160 samples in 8-bit mode and 176 in 9-bit mode. It is never set before the first character.
- R9: A `rd_status` pulse followed by a `rd_data` pulse clears `flag_full`, `flag_ovr`, `flag_noise`, `flag_frame` and `flag_idle`. A `rd_data` pulse with no `rd_status` pulse before it clears nothing.
- R10: `irq` is high when (`ien_rx` and (`flag_full` or `flag_ovr`)) or (`ien_idle` and `flag_idle`).
- R11: While `rx_en` is low, frames on the line produce no character.
- R12: After reset, all flags, `irq`, `data_out` and `bit8_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe, sixteen per bit period |
| rx_line | input | 1 | Serial input, idles high |
| rx_en | input | 1 | Receiver enable |
| len9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| rd_status | input | 1 | Status-read strobe |
| rd_data | input | 1 | Data-read strobe |
| ien_rx | input | 1 | Interrupt enable for data ready or overrun |
| ien_idle | input | 1 | Interrupt enable for idle line |
| data_out | output | 8 | Held character, data bits 7..0 |
| bit8_out | output | 1 | Held ninth data bit |
| flag_full | output | 1 | Holding register full |
| flag_ovr | output | 1 | Overrun |
| flag_noise | output | 1 | Disagreeing samples in the held character |
| flag_frame | output | 1 | Stop bit sampled low |
| flag_idle | output | 1 | Idle line seen |
| irq | output | 1 | Interrupt request |

## Verification
A change on `rx_line` is seen by the sampling logic two clocks later, through the synchroniser. `flag_full`, the data and the error flags change two clocks after the strobe that takes sample 10 of the stop bit. `flag_idle` changes two clocks after the strobe that takes the final idle sample. The bench changes the line only on the falling edge just before a strobe, so each driven value yields exactly one sample per strobe. It checks frame results only after the full sixteen stop samples have been sent, and it waits several clocks after idle stimulus before looking. The monitor takes data at the falling edge where `flag_full` first reads high. The idle window is checked on both sides of its threshold, with margins larger than the uncertainty of one strobe.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       bit8;
    logic       noisy;
    logic       bad_stop;
  } rx_char_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_line,
  output logic       samp_stb,
  output logic       samp_val,
  output logic [2:0] prior3
);

  logic [SYNC_STAGES-1:0] stage_q;
  logic [2:0]             prior3_d;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= rx_line;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign samp_stb = tick;
  assign samp_val = stage_q[SYNC_STAGES-1];

  always_comb begin
    prior3_d = prior3;
    if (tick) prior3_d = {prior3[1:0], samp_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prior3 <= 3'b000;
    else        prior3 <= prior3_d;
  end

endmodule

// File: rtl/uart_os_rx_framer.sv
module uart_os_rx_framer
  import uart_os_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       len9,
  input  logic       samp_stb,
  input  logic       samp_val,
  input  logic [2:0] prior3,
  output logic       in_idle,
  output logic       char_done,
  output rx_char_t   char_q
);

  localparam int CW = $clog2(OSR + 1);
  localparam logic [CW-1:0] CHK_A  = CW'(OSR / 2 - 5);
  localparam logic [CW-1:0] CHK_B  = CW'(OSR / 2 - 3);
  localparam logic [CW-1:0] CHK_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] VOTE_A = CW'(OSR / 2);
  localparam logic [CW-1:0] VOTE_B = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] VOTE_C = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] LAST_S = CW'(OSR);

  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d, idx;
  logic [3:0]     bitn_q, bitn_d, last_bit;
  logic [8:0]     sh_q, sh_d;
  logic           va_q, va_d, vb_q, vb_d;
  logic           noise_q, noise_d;
  logic           mode9_q, mode9_d;
  logic           done_d;
  rx_char_t       char_d;
  logic           vote, split;

  assign idx      = cnt_q + 1'b1;
  assign vote     = maj3(va_q, vb_q, samp_val);
  assign split    = split3(va_q, vb_q, samp_val);
  assign last_bit = mode9_q ? 4'd8 : 4'd7;
  assign in_idle  = (state_q == RX_IDLE) && rx_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    va_d    = va_q;
    vb_d    = vb_q;
    noise_d = noise_q;
    mode9_d = mode9_q;
    done_d  = 1'b0;
    char_d  = char_q;
    unique case (state_q)
      RX_IDLE: begin
        if (samp_stb && !samp_val && prior3 == 3'b111) begin
          state_d = RX_START;
          cnt_d   = CW'(1);
          bitn_d  = 4'd0;
          noise_d = 1'b0;
          mode9_d = len9;
        end
      end
      RX_START: begin
        if (samp_stb) begin
          cnt_d = idx;
          if (idx == CHK_A) va_d = samp_val;
          if (idx == CHK_B) vb_d = samp_val;
          if (idx == CHK_C) begin
            if (vote) state_d = RX_IDLE;
            else      noise_d = noise_q | split;
          end
          if (idx == LAST_S) begin
            cnt_d   = '0;
            state_d = RX_DATA;
          end
        end
      end
      RX_DATA: begin
        if (samp_stb) begin
          cnt_d = idx;
          if (idx == VOTE_A) va_d = samp_val;
          if (idx == VOTE_B) vb_d = samp_val;
          if (idx == VOTE_C) begin
            sh_d    = {vote, sh_q[8:1]};
            noise_d = noise_q | split;
          end
          if (idx == LAST_S) begin
            cnt_d = '0;
            if (bitn_q == last_bit) begin
              state_d = RX_STOP;
              bitn_d  = 4'd0;
            end else begin
              bitn_d = bitn_q + 4'd1;
            end
          end
        end
      end
      RX_STOP: begin
        if (samp_stb) begin
          cnt_d = idx;
          if (idx == VOTE_A) va_d = samp_val;
          if (idx == VOTE_B) vb_d = samp_val;
          if (idx == VOTE_C) begin
            done_d          = 1'b1;
            char_d.data     = mode9_q ? sh_q[7:0] : sh_q[8:1];
            char_d.bit8     = mode9_q & sh_q[8];
            char_d.noisy    = noise_q | split;
            char_d.bad_stop = ~vote;
            state_d         = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
    if (!rx_en) begin
      state_d = RX_IDLE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      va_q      <= 1'b0;
      vb_q      <= 1'b0;
      noise_q   <= 1'b0;
      mode9_q   <= 1'b0;
      char_done <= 1'b0;
      char_q    <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      bitn_q    <= bitn_d;
      sh_q      <= sh_d;
      va_q      <= va_d;
      vb_q      <= vb_d;
      noise_q   <= noise_d;
      mode9_q   <= mode9_d;
      char_done <= done_d;
      char_q    <= char_d;
    end
  end

endmodule

// File: rtl/uart_os_rx_idle.sv
module uart_os_rx_idle #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_stb,
  input  logic samp_val,
  input  logic in_idle,
  input  logic char_done,
  input  logic len9,
  output logic idle_evt
);

  localparam int LIM8 = 10 * OSR;
  localparam int LIM9 = 11 * OSR;
  localparam int CW   = $clog2(LIM9 + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          armed_q, armed_d, evt_d;

  assign lim_m1 = len9 ? CW'(LIM9 - 1) : CW'(LIM8 - 1);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    evt_d   = 1'b0;
    if (char_done) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (!in_idle) begin
      cnt_d = '0;
    end else if (samp_stb) begin
      if (!samp_val) begin
        cnt_d = '0;
      end else if (armed_q) begin
        if (cnt_q == lim_m1) begin
          evt_d   = 1'b1;
          armed_d = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      idle_evt <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      armed_q  <= armed_d;
      idle_evt <= evt_d;
    end
  end

endmodule

// File: rtl/uart_os_rx_status.sv
module uart_os_rx_status
  import uart_os_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_done,
  input  rx_char_t   char_in,
  input  logic       idle_evt,
  input  logic       rd_status,
  input  logic       rd_data,
  input  logic       ien_rx,
  input  logic       ien_idle,
  output logic [7:0] data_out,
  output logic       bit8_out,
  output logic       flag_full,
  output logic       flag_ovr,
  output logic       flag_noise,
  output logic       flag_frame,
  output logic       flag_idle,
  output logic       irq
);

  logic       clr, armed_q, armed_d;
  logic [7:0] data_d;
  logic       bit8_d, full_d, ovr_d, noise_d, frame_d, idle_d;

  assign clr = rd_data & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (rd_data)        armed_d = 1'b0;
    else if (rd_status) armed_d = 1'b1;

    data_d  = data_out;
    bit8_d  = bit8_out;
    full_d  = flag_full  & ~clr;
    ovr_d   = flag_ovr   & ~clr;
    noise_d = flag_noise & ~clr;
    frame_d = flag_frame & ~clr;
    idle_d  = flag_idle  & ~clr;

    if (char_done) begin
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        full_d  = 1'b1;
        data_d  = char_in.data;
        bit8_d  = char_in.bit8;
        noise_d = char_in.noisy;
        frame_d = char_in.bad_stop;
      end
    end
    if (idle_evt) idle_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      data_out   <= '0;
      bit8_out   <= 1'b0;
      flag_full  <= 1'b0;
      flag_ovr   <= 1'b0;
      flag_noise <= 1'b0;
      flag_frame <= 1'b0;
      flag_idle  <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      data_out   <= data_d;
      bit8_out   <= bit8_d;
      flag_full  <= full_d;
      flag_ovr   <= ovr_d;
      flag_noise <= noise_d;
      flag_frame <= frame_d;
      flag_idle  <= idle_d;
    end
  end

  assign irq = (ien_rx & (flag_full | flag_ovr)) | (ien_idle & flag_idle);

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic       rx_en,
  input  logic       len9,
  input  logic       rd_status,
  input  logic       rd_data,
  input  logic       ien_rx,
  input  logic       ien_idle,
  output logic [7:0] data_out,
  output logic       bit8_out,
  output logic       flag_full,
  output logic       flag_ovr,
  output logic       flag_noise,
  output logic       flag_frame,
  output logic       flag_idle,
  output logic       irq
);

  logic       samp_stb, samp_val, in_idle, char_done, idle_evt;
  logic [2:0] prior3;
  rx_char_t   char_q;

  uart_os_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_line(rx_line),
    .samp_stb(samp_stb), .samp_val(samp_val), .prior3(prior3)
  );

  uart_os_rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .len9(len9),
    .samp_stb(samp_stb), .samp_val(samp_val), .prior3(prior3),
    .in_idle(in_idle), .char_done(char_done), .char_q(char_q)
  );

  uart_os_rx_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_val(samp_val),
    .in_idle(in_idle), .char_done(char_done), .len9(len9), .idle_evt(idle_evt)
  );

  uart_os_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_in(char_q),
    .idle_evt(idle_evt), .rd_status(rd_status), .rd_data(rd_data),
    .ien_rx(ien_rx), .ien_idle(ien_idle),
    .data_out(data_out), .bit8_out(bit8_out), .flag_full(flag_full),
    .flag_ovr(flag_ovr), .flag_noise(flag_noise), .flag_frame(flag_frame),
    .flag_idle(flag_idle), .irq(irq)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_data,
  input logic       ien_rx,
  input logic       ien_idle,
  input logic [7:0] data_out,
  input logic       flag_full,
  input logic       flag_ovr,
  input logic       flag_noise,
  input logic       flag_frame,
  input logic       irq
);

  p_ovr_rises_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $past(flag_full));

  p_held_byte_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_full && $past(flag_full) && !$past(rd_data)) |-> $stable(data_out));

  p_full_falls_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_full) |-> $past(rd_data));

  p_frame_with_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_frame |-> flag_full);

  p_noise_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_noise |-> flag_full);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_rx && !ien_idle) |-> !irq);

  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$past(rx_en) && !$past(rx_en, 2)) |-> !$rose(flag_full));

endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_data(rd_data),
  .ien_rx(ien_rx), .ien_idle(ien_idle), .data_out(data_out),
  .flag_full(flag_full), .flag_ovr(flag_ovr), .flag_noise(flag_noise),
  .flag_frame(flag_frame), .irq(irq)
);

// File: tb/uart_os_rx_bench.sv
`timescale 1ns/1ps
module uart_os_rx_bench;

  logic       clk, rst_n, tick16, rx_line, rx_en, len9;
  logic       rd_status, rd_data, ien_rx, ien_idle;
  logic [7:0] data_out;
  logic       bit8_out, flag_full, flag_ovr, flag_noise, flag_frame, flag_idle, irq;
  logic [1:0] tcnt;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [7:0] data;
    logic       b8;
    logic       noisy;
    logic       bad;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  logic full_seen = 1'b0;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .rx_en(rx_en), .len9(len9), .rd_status(rd_status), .rd_data(rd_data),
    .ien_rx(ien_rx), .ien_idle(ien_idle), .data_out(data_out),
    .bit8_out(bit8_out), .flag_full(flag_full), .flag_ovr(flag_ovr),
    .flag_noise(flag_noise), .flag_frame(flag_frame), .flag_idle(flag_idle),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= 2'd0;
      tick16 <= 1'b0;
    end else begin
      tcnt   <= tcnt + 2'd1;
      tick16 <= (tcnt == 2'd3);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick16);
      if (i == 0) rx_line = v;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Driver: bit index 0 is the start bit, the last index is the stop bit.
  task automatic send_frame(input logic [8:0] val, input bit nine, input logic stop_v,
                            input int gbit, input int gsmp);
    int nb;
    nb = nine ? 9 : 8;
    for (int b = 0; b < nb + 2; b++) begin
      for (int s = 1; s <= 16; s++) begin
        logic v;
        if (b == 0)           v = 1'b0;
        else if (b == nb + 1) v = stop_v;
        else                  v = val[b-1];
        if (b == gbit && s == gsmp) v = ~v;
        hold(v, 1);
      end
    end
  endtask

  task automatic expect_char(input logic [7:0] d, input logic b8, input logic nz, input logic bad);
    exp_t e;
    e.data = d; e.b8 = b8; e.noisy = nz; e.bad = bad;
    exp_q.push_back(e);
  endtask

  task automatic do_clear();
    @(negedge clk) rd_status = 1'b1;
    @(negedge clk) begin rd_status = 1'b0; rd_data = 1'b1; end
    @(negedge clk) rd_data = 1'b0;
  endtask

  // Monitor: compares each newly loaded character against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && flag_full && !full_seen) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R3 unexpected character actual=%0h expected=none", data_out);
      end else begin
        cur = exp_q.pop_front();
        chk("R3 data byte", {24'd0, data_out}, {24'd0, cur.data});
        chk("R4 ninth bit", {31'd0, bit8_out}, {31'd0, cur.b8});
        chk("R5 noise flag", {31'd0, flag_noise}, {31'd0, cur.noisy});
        chk("R6 frame flag", {31'd0, flag_frame}, {31'd0, cur.bad});
      end
    end
    full_seen = flag_full;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b0; rx_en = 1'b1; len9 = 1'b0;
    rd_status = 1'b0; rd_data = 1'b0; ien_rx = 1'b1; ien_idle = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset flags", {27'd0, flag_full, flag_ovr, flag_noise, flag_frame, flag_idle}, 32'd0);
    chk("R12 reset irq", {31'd0, irq}, 32'd0);
    chk("R12 reset data", {23'd0, bit8_out, data_out}, 32'd0);

    // R1: only two high samples before the low start, so no character
    hold(1'b0, 30);
    hold(1'b1, 2);
    send_frame(9'h000, 1'b0, 1'b1, -1, 0);
    hold(1'b1, 200);
    settle();
    chk("R1 two-high preamble ignored", {31'd0, flag_full}, 32'd0);
    chk("R8 no idle before first char", {31'd0, flag_idle}, 32'd0);

    // R3 plain byte, R10 irq, R9 lone data read
    expect_char(8'hA5, 1'b0, 1'b0, 1'b0);
    send_frame(9'h0A5, 1'b0, 1'b1, -1, 0);
    settle();
    chk("R3 full after frame", {31'd0, flag_full}, 32'd1);
    chk("R10 irq on full", {31'd0, irq}, 32'd1);
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    settle();
    chk("R9 lone data read keeps full", {31'd0, flag_full}, 32'd1);
    do_clear();
    settle();
    chk("R9 status+data read clears full", {31'd0, flag_full}, 32'd0);
    chk("R10 irq drops", {31'd0, irq}, 32'd0);

    // R5 one flipped middle sample in data bit 2
    expect_char(8'h3C, 1'b0, 1'b1, 1'b0);
    send_frame(9'h03C, 1'b0, 1'b1, 3, 9);
    settle();
    do_clear();
    settle();
    chk("R9 noise cleared", {31'd0, flag_noise}, 32'd0);

    // R2 noisy start sample 5, character still taken
    expect_char(8'h5A, 1'b0, 1'b1, 1'b0);
    send_frame(9'h05A, 1'b0, 1'b1, 0, 5);
    settle();
    do_clear();

    // R2 short low pulse is abandoned
    hold(1'b1, 4);
    hold(1'b0, 2);
    hold(1'b1, 40);
    settle();
    chk("R2 false start dropped full", {31'd0, flag_full}, 32'd0);
    chk("R2 false start no noise", {31'd0, flag_noise}, 32'd0);

    // R4 nine-bit frame
    len9 = 1'b1;
    expect_char(8'hC3, 1'b1, 1'b0, 1'b0);
    send_frame(9'h1C3, 1'b1, 1'b1, -1, 0);
    settle();
    chk("R4 nine-bit received", {31'd0, flag_full}, 32'd1);
    do_clear();
    len9 = 1'b0;
    hold(1'b1, 4);

    // R7 overrun
    expect_char(8'h11, 1'b0, 1'b0, 1'b0);
    send_frame(9'h011, 1'b0, 1'b1, -1, 0);
    hold(1'b1, 16);
    send_frame(9'h022, 1'b0, 1'b1, -1, 0);
    settle();
    chk("R7 overrun flag", {31'd0, flag_ovr}, 32'd1);
    chk("R7 held byte kept", {24'd0, data_out}, 32'h11);
    chk("R10 irq on overrun", {31'd0, irq}, 32'd1);
    do_clear();
    settle();
    chk("R9 overrun cleared", {31'd0, flag_ovr}, 32'd0);

    // R6 bad stop bit, then a break; R1 three highs then a frame
    expect_char(8'h81, 1'b0, 1'b0, 1'b1);
    send_frame(9'h081, 1'b0, 1'b0, -1, 0);
    hold(1'b0, 30);
    settle();
    chk("R6 frame flag held", {31'd0, flag_frame}, 32'd1);
    chk("R6 char still loaded", {31'd0, flag_full}, 32'd1);
    do_clear();
    settle();
    chk("R9 frame cleared", {31'd0, flag_frame}, 32'd0);
    hold(1'b1, 3);
    expect_char(8'h00, 1'b0, 1'b0, 1'b0);
    send_frame(9'h000, 1'b0, 1'b1, -1, 0);
    settle();
    chk("R1 three-high preamble accepted", {31'd0, flag_full}, 32'd1);
    do_clear();

    // R8 idle window: about 150 high samples then past 160
    expect_char(8'h42, 1'b0, 1'b0, 1'b0);
    send_frame(9'h042, 1'b0, 1'b1, -1, 0);
    do_clear();
    hold(1'b1, 144);
    settle();
    chk("R8 idle not yet", {31'd0, flag_idle}, 32'd0);
    hold(1'b1, 12);
    settle();
    chk("R8 idle set", {31'd0, flag_idle}, 32'd1);
    chk("R10 irq on idle", {31'd0, irq}, 32'd1);
    ien_idle = 1'b0;
    @(negedge clk);
    chk("R10 idle irq masked", {31'd0, irq}, 32'd0);
    ien_idle = 1'b1;
    do_clear();
    settle();
    chk("R9 idle cleared", {31'd0, flag_idle}, 32'd0);

    // R11 receiver disabled
    rx_en = 1'b0;
    send_frame(9'h077, 1'b0, 1'b1, -1, 0);
    hold(1'b1, 4);
    settle();
    chk("R11 disabled no char", {31'd0, flag_full}, 32'd0);
    rx_en = 1'b1;

    chk("R3 all expected chars seen", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule